// File: doc/BRIEF.md
# MDIO Management Master with Single Command/Status Word

This block lets a processor reach Ethernet PHY management registers through one 32-bit word. A write to that word carries the whole request: a go bit, a read or write selector, the 5-bit PHY address, the 5-bit register address and, for writes, 16 bits of data. Once it accepts a request, the block generates the management clock and shifts a complete Clause 22 frame onto the data pin. The busy flag in the top bit of the word stays set until the frame ends.

Software polls the busy flag before it issues a request and polls it again before it collects a result. When a read frame ends, the 16 bits received from the PHY appear in the low half of the same word, and the busy flag clears in the same clock cycle. The management clock runs only while a frame is in progress. Its half period is a parameter counted in system clocks.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the word reads 0, MDC is low, the data pin driver is off (`mdio_oe` = 0) and `mdio_o` is 1.
- R2: The block accepts a write of the word while idle when bit 16 (go) is 1 and exactly one of bit 19 (read) and bit 18 (write) is 1. Bit 31 then reads 1 from the next clock cycle on.
- R3: The block ignores a write while idle when go is 0, or when read and write are both 1, or when both are 0. It stays idle, MDC shows no rising edge and the word is unchanged.
- R4: The block ignores any write of the word while bit 31 is 1, including a write in the last busy cycle. The running frame, its length and its result are not affected.
- R5: A frame is sent MSB first and contains, in order: 32 ones, start `01`, opcode `10` for a read or `01` for a write, the PHY address from bits 24:20, the register address from bits 29:25, and then, for a write, turnaround `10` followed by data bits 15:0. The driver is enabled for all 64 bit times of a write.
- R6: While a frame runs, MDC has a period of 2*`MDC_HALF` system clocks and there are exactly 64 MDC rising edges per frame. MDC is low while idle, and `mdio_o` changes only in the cycle in which MDC falls.
- R7: For a read, `mdio_oe` is 0 from the first turnaround bit to the end of the frame, and `mdio_i` is sampled at each rising MDC edge of the 16 data bits. When bit 31 clears, bits 15:0 hold the received data MSB first, and bits 30:16 read 0.
- R8: Bit 31 reads 1 for exactly 128*`MDC_HALF` system clock cycles after the accepting edge, and clears on the edge where the final MDC fall occurs.
- R9: A write frame leaves bits 15:0 unchanged, so they keep the result of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word being written |
| reg_rdata | output | 32 | Status word: busy in bit 31, result in bits 15:0 |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven on the management data pin |
| mdio_oe | output | 1 | Driver enable for the management data pin |
| mdio_i | input | 1 | Value sampled from the management data pin |

## Verification
Two events can fall on the same clock edge: a new command write and the end of a frame. At that edge the final MDC fall clears busy and, for a read, loads the result. The bench keeps a read busy for exactly its expected length and then presents a valid write command in the last cycle in which busy still reads 1. It expects the command to be dropped: in the next cycle busy must read 0 and the low half must already show the read data. It also presents a command in the middle of a frame and expects the frame bits seen on MDC rises to match the read header, with no disturbance.

// File: rtl/mdio_pkg.sv
// Shared constants, types and the frame builder for the MDIO command master.
// Assumes Clause 22 framing with a fixed 32-bit preamble.
package mdio_pkg;

    // Positions in the command/status word that software decodes
    localparam int BUSY_POS  = 31;
    localparam int RD_POS    = 19;
    localparam int WR_POS    = 18;
    localparam int GO_POS    = 16;
    localparam int PHY_LSB   = 20;
    localparam int REG_LSB   = 25;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;

    // Frame geometry
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 4 + 2*ADDR_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + 2*ADDR_W;
    localparam int DAT_POS   = TA_POS + 2;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } opcode_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    // Builds the full serial frame, first bit in the MSB
    function automatic logic [FRAME_LEN-1:0] frame_word(input mdio_cmd_t c);
        opcode_e           op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        op  = c.is_read ? OPC_READ : OPC_WRITE;
        ta  = c.is_read ? 2'b11 : 2'b10;
        dat = c.is_read ? {DATA_W{1'b1}} : c.wdata;
        return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Management clock generator.
// Divides clk by 2*HALF while run is high; holds MDC low and the counter
// cleared while run is low. The event outputs announce the edge at which
// MDC will change, so that other logic can act on that same edge.
module mdio_mdc_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] hcnt;
    logic          mdc_q;
    logic          tick;

    assign tick = (hcnt == LAST);

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt  <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            hcnt  <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            hcnt  <= hcnt + 1'b1;
        end
    end

    assign mdc      = mdc_q;
    assign rise_evt = run && tick && !mdc_q;
    assign fall_evt = run && tick && mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer.
// Loads the whole frame into a shift register on launch and moves it one bit
// on each MDC fall. It releases the pin from the turnaround of a read and
// captures read data on MDC rises. done is high on the edge of the final fall.
// Assumes launch is only raised while idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mdio_cmd_t         cmd,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IW = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] shreg;
    logic [IW-1:0]        idx;
    logic                 act_q;
    logic                 rd_q;
    logic [DATA_W-1:0]    cap;
    logic                 last_bit;
    logic                 in_ta;
    logic                 in_data;

    assign last_bit = (idx == IW'(FRAME_LEN - 1));
    assign in_ta    = (idx >= IW'(TA_POS));
    assign in_data  = (idx >= IW'(DAT_POS));
    assign done     = act_q && fall_evt && last_bit;

    // Frame start, bit advance and frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            rd_q  <= 1'b0;
            idx   <= '0;
            shreg <= '1;
        end else if (launch && !act_q) begin
            act_q <= 1'b1;
            rd_q  <= cmd.is_read;
            idx   <= '0;
            shreg <= frame_word(cmd);
        end else if (act_q && fall_evt) begin
            if (last_bit) begin
                act_q <= 1'b0;
            end else begin
                idx   <= idx + 1'b1;
                shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
            end
        end
    end

    // Read data capture on MDC rises during the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (act_q && rd_q && in_data && rise_evt) begin
            cap <= {cap[DATA_W-2:0], mdio_i};
        end
    end

    assign active  = act_q;
    assign mdio_o  = act_q ? shreg[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = act_q && !(rd_q && in_ta);
    assign rd_data = cap;

endmodule

// File: rtl/mdio_cmd_master.sv
// MDIO command master top.
// A single 32-bit word takes the request and reports busy and the read
// result. It accepts a request only while idle and only when the command is
// well formed. Assumes reg_wr is a one-cycle strobe synchronous to clk.
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int PAD_W = 32 - 1 - DATA_W;

    logic              busy_q;
    logic              op_rd_q;
    logic [DATA_W-1:0] rdat_q;
    logic              cmd_ok;
    logic              accept;
    mdio_cmd_t         cmd;
    logic              seq_active;
    logic              seq_done;
    logic [DATA_W-1:0] seq_rdata;
    logic              rise_evt;
    logic              fall_evt;
    logic              unused_bits;

    assign cmd_ok = reg_wdata[GO_POS] && (reg_wdata[RD_POS] ^ reg_wdata[WR_POS]);
    assign accept = reg_wr && !busy_q && cmd_ok;

    assign cmd.is_read = reg_wdata[RD_POS];
    assign cmd.phy     = reg_wdata[PHY_LSB +: ADDR_W];
    assign cmd.regad   = reg_wdata[REG_LSB +: ADDR_W];
    assign cmd.wdata   = reg_wdata[DATA_W-1:0];

    assign unused_bits = ^{reg_wdata[31:30], reg_wdata[17]};

    // Busy flag: set on acceptance, cleared when the frame ends
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (accept)   busy_q <= 1'b1;
        else if (seq_done) busy_q <= 1'b0;
    end

    // Remember whether the running frame is a read
    always_ff @(posedge clk) begin
        if (!rst_n)      op_rd_q <= 1'b0;
        else if (accept) op_rd_q <= reg_wdata[RD_POS];
    end

    // Result holding register, loaded only when a read ends
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdat_q <= '0;
        else if (seq_done && op_rd_q) rdat_q <= seq_rdata;
    end

    assign reg_rdata = {busy_q, {PAD_W{1'b0}}, rdat_q};

    mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_active),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (accept),
        .cmd      (cmd),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .active   (seq_active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (seq_done),
        .rd_data  (seq_rdata)
    );

endmodule

// File: rtl/mdio_cmd_master_chk.sv
// Property checker for mdio_cmd_master, attached by bind.
// Observes only the top-level ports.
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2
    cmd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && reg_wr && reg_wdata[16] && (reg_wdata[19] != reg_wdata[18]))
        |=> reg_rdata[31]);

    // R3
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && reg_wr && !(reg_wdata[16] && (reg_wdata[19] != reg_wdata[18])))
        |=> (!reg_rdata[31] && $stable(reg_rdata)));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31] |=> (!reg_rdata[31] || $stable(reg_rdata[15:0])));

    // R6
    mdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R6
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdc);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> (!mdio_oe && mdio_o));

    // R5
    drive_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[31]) |-> (mdio_oe && mdio_o && !mdc));

endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_cmd_master.sv
`timescale 1ns/1ps
// Directed bench for mdio_cmd_master with a behavioural PHY on the pins.
module sim_mdio_cmd_master;
    localparam int HALF   = 2;
    localparam int FRAMEC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    // PHY model state
    int          cyc = 0, last_rise = 0, nrise = 0, base = 0;
    int          per_bad = 0, edge_bad = 0;
    logic        pm = 1'b0, pmo = 1'b1;
    logic [63:0] obs_bits = '0, oe_bits = '0;
    logic [15:0] resp = '0;

    always #2 clk = ~clk;

    mdio_cmd_master #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // Behavioural PHY: records bits on MDC rises, answers reads after MDC falls
    always @(negedge clk) begin
        int n;
        cyc <= cyc + 1;
        pm  <= mdc;
        pmo <= mdio_o;
        if (mdc === 1'b1 && pm === 1'b0) begin
            if ((nrise - base) >= 1 && (cyc - last_rise) != 2*HALF) per_bad <= per_bad + 1;
            last_rise <= cyc;
            nrise     <= nrise + 1;
            obs_bits  <= {obs_bits[62:0], mdio_o};
            oe_bits   <= {oe_bits[62:0], mdio_oe};
        end
        if (mdc === 1'b0 && pm === 1'b1) begin
            n = nrise - base;
            mdio_i <= (n >= 48 && n < 64) ? resp[63-n] : 1'b1;
        end
        if (mdio_o !== pmo && !(pm === 1'b1 && mdc === 1'b0)) edge_bad <= edge_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit rd, input bit wr, input bit go,
                                       input logic [4:0] phy, input logic [4:0] rg,
                                       input logic [15:0] d);
        return {2'b00, rg, phy, rd, wr, 1'b0, go, d};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    // Counts busy samples, the first one already taken after issue
    task automatic wait_idle(output int n);
        n = 1;
        while (reg_rdata[31] && n < 4*FRAMEC) begin
            @(negedge clk);
            if (reg_rdata[31]) n++;
        end
    endtask

    task automatic t_reset;
        chk(reg_rdata == 32'h0, "R1", "word after reset", 64'(reg_rdata), 64'h0);
        chk(mdc == 1'b0, "R1", "mdc after reset", 64'(mdc), 64'h0);
        chk(mdio_oe == 1'b0, "R1", "oe after reset", 64'(mdio_oe), 64'h0);
        chk(mdio_o == 1'b1, "R1", "mdio_o after reset", 64'(mdio_o), 64'h1);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        int n, pb, eb;
        logic [15:0] old;
        logic [63:0] exp;
        base = nrise; pb = per_bad; eb = edge_bad; old = reg_rdata[15:0];
        issue(mk(1'b0, 1'b1, 1'b1, phy, rg, d));
        chk(reg_rdata[31] == 1'b1, "R2", "busy after write cmd", 64'(reg_rdata[31]), 64'h1);
        wait_idle(n);
        chk(n == FRAMEC, "R8", "busy cycles write", 64'(n), 64'(FRAMEC));
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
        chk((nrise - base) == 64, "R6", "mdc rises write", 64'(nrise - base), 64'd64);
        chk(obs_bits == exp, "R5", "write frame", obs_bits, exp);
        chk(oe_bits == '1, "R5", "write oe", oe_bits, '1);
        chk(per_bad == pb && edge_bad == eb, "R6", "mdc period/edge faults",
            64'(per_bad - pb + edge_bad - eb), 64'h0);
        chk(reg_rdata == {16'h0, old}, "R9", "word after write", 64'(reg_rdata), 64'(old));
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] r);
        int n;
        logic [45:0] hdr;
        resp = r; base = nrise;
        issue(mk(1'b1, 1'b0, 1'b1, phy, rg, 16'h1234));
        chk(reg_rdata[31] == 1'b1, "R2", "busy after read cmd", 64'(reg_rdata[31]), 64'h1);
        wait_idle(n);
        chk(n == FRAMEC, "R8", "busy cycles read", 64'(n), 64'(FRAMEC));
        hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
        chk(obs_bits[63:18] == hdr, "R5", "read header", 64'(obs_bits[63:18]), 64'(hdr));
        chk(oe_bits == {{46{1'b1}}, {18{1'b0}}}, "R7", "read oe pattern",
            oe_bits, {{46{1'b1}}, {18{1'b0}}});
        chk(reg_rdata == {16'h0, r}, "R7", "read result", 64'(reg_rdata), 64'(r));
    endtask

    task automatic t_bad(input logic [31:0] w, input string what);
        logic [31:0] old;
        base = nrise; old = reg_rdata;
        issue(w);
        chk(reg_rdata == old, "R3", what, 64'(reg_rdata), 64'(old));
        repeat (20) @(negedge clk);
        chk(nrise == base, "R3", "no mdc after bad cmd", 64'(nrise - base), 64'h0);
        chk(!mdc && !mdio_oe && mdio_o, "R3", "pins idle after bad cmd",
            64'({mdc, mdio_oe, mdio_o}), 64'h1);
    endtask

    task automatic t_collide;
        logic [45:0] hdr;
        resp = 16'hA5C3; base = nrise;
        issue(mk(1'b1, 1'b0, 1'b1, 5'h03, 5'h09, 16'h0));
        for (int k = 2; k <= FRAMEC - 1; k++) begin
            @(negedge clk);
            if (k == 60) begin
                reg_wr = 1'b1;
                reg_wdata = mk(1'b0, 1'b1, 1'b1, 5'h1E, 5'h11, 16'h7777);
            end else if (k == 61) begin
                reg_wr = 1'b0;
                reg_wdata = '0;
            end
        end
        @(negedge clk);
        chk(reg_rdata[31] == 1'b1, "R8", "busy in last cycle", 64'(reg_rdata[31]), 64'h1);
        reg_wr = 1'b1;
        reg_wdata = mk(1'b0, 1'b1, 1'b1, 5'h02, 5'h02, 16'h4444);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
        chk(reg_rdata[31] == 1'b0, "R4", "cmd at frame end dropped", 64'(reg_rdata[31]), 64'h0);
        chk(reg_rdata[15:0] == 16'hA5C3, "R4", "read result kept", 64'(reg_rdata[15:0]), 64'hA5C3);
        hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h09};
        chk(obs_bits[63:18] == hdr, "R4", "frame undisturbed", 64'(obs_bits[63:18]), 64'(hdr));
        chk((nrise - base) == 64, "R4", "frame length kept", 64'(nrise - base), 64'd64);
        repeat (10) @(negedge clk);
        chk(nrise - base == 64, "R4", "no frame from dropped cmd", 64'(nrise - base), 64'd64);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(5'h01, 5'h04, 16'h05E1);
        t_read(5'h1F, 5'h10, 16'hBEEF);
        t_write(5'h00, 5'h1F, 16'h8000);
        t_bad(mk(1'b1, 1'b1, 1'b1, 5'h01, 5'h01, 16'h1111), "both read and write");
        t_bad(mk(1'b0, 1'b0, 1'b1, 5'h01, 5'h01, 16'h2222), "neither read nor write");
        t_bad(mk(1'b1, 1'b0, 1'b0, 5'h01, 5'h01, 16'h3333), "go bit clear");
        t_collide();
        t_read(5'h15, 5'h0A, 16'h0001);
        t_write(5'h1F, 5'h00, 16'hFFFF);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule